// File: doc/BRIEF.md
# Axon Event Crossbar Fanout

This block collects axon address events for a timestep and turns them into synaptic deliveries. Each incoming event names one axon and marks that axon as active. A `tick` closes the timestep: the collected set is latched as the replay set, and a fresh collection set starts for the next timestep. During replay a token walks the active axons from the lowest index upwards. For each axon it reads that axon's row of a binary synapse crossbar in one operation. It emits the whole row as a fanout vector, with one bit per neuron, together with the axon's synapse type.

Rows and types are loaded through a simple write port. The output is a valid/ready stream, and one beat carries one axon's complete fanout. Neuron arithmetic sits downstream and is not part of this block.

Top module: `axon_fanout`

## Requirements
- R1: After reset `out_valid` is 0, `done` is 1 and `ev_ready` is 1.
- R2: An accepted event (`ev_valid` high while `ev_ready` is high) marks axon `ev_axon` for the next replay only. Without a `tick`, no row is ever emitted.
- R3: Any number of events for the same axon within one collection period produce exactly one delivery of that axon's row.
- R4: After a `tick`, active axons are emitted in strictly ascending index order. While `out_ready` stays high, one beat fires on every cycle and inactive axons take no cycles. The first beat becomes valid two clock edges after the `tick` edge.
- R5: Each beat carries `out_axon`, the crossbar row of that axon in `out_row` (bit n = synapse to neuron n), and its configured 2-bit type in `out_type`.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_axon`, `out_row` and `out_type` hold their values on the next cycle.
- R7: Events arriving during a replay, or in the same cycle as a `tick`, are delivered only after the following `tick`.
- R8: `done` is 1 exactly when no axon is awaiting delivery and no beat is pending. Without a `tick`, it stays 1 once it has been raised.
- R9: A `tick` that arrives while replay is still in progress keeps the undelivered axons and merges the newly collected ones into them. The walk again starts from the lowest index.
- R10: A configuration write (`cfg_we`) replaces the row and type of `cfg_axon` from the next cycle on. A beat loaded in the same cycle as the write carries the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Axon event present |
| ev_ready | output | 1 | Event can be taken (always 1) |
| ev_axon | input | 6 | Axon index of the event |
| tick | input | 1 | Timestep boundary |
| cfg_we | input | 1 | Write crossbar row and type |
| cfg_axon | input | 6 | Axon to configure |
| cfg_row | input | 32 | Synapse bits, one per neuron |
| cfg_type | input | 2 | Synapse type of the axon |
| out_valid | output | 1 | Fanout beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_axon | output | 6 | Axon being delivered |
| out_row | output | 32 | Fanout vector for the neurons |
| out_type | output | 2 | Synapse type for this beat |
| done | output | 1 | Nothing left to deliver |

## Verification
Three pairs of operations can land in the same cycle. The first pair is the collection of a new event and the timestep switch. The bench provokes it by driving `ev_valid` together with `tick`, and also during a replay. It judges the result by where that axon shows up: only after the second tick. The second pair is a `tick` while undelivered axons remain, with downstream stalled. The merged walk must still ascend from the lowest index. The third pair is a configuration write to the very row being loaded into the output, which must leave the old contents in that beat. A behavioural model in the bench tracks both activity sets, the rows and the output register, and is compared against the ports on every cycle.

// File: rtl/axfo_pkg.sv
package axfo_pkg;
  localparam int TYPE_W = 2;
  typedef logic [TYPE_W-1:0] syn_type_t;
endpackage

// File: rtl/axfo_activity.sv
module axfo_activity #(
  parameter int N_AXON = 64,
  localparam int AW = $clog2(N_AXON)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_fire,
  input  logic [AW-1:0] ev_axon,
  input  logic          tick,
  input  logic          take,
  output logic [AW-1:0] pick_axon,
  output logic          any_active
);
  logic [N_AXON-1:0] pend_q, act_q, clr_vec, set_vec;

  function automatic logic [AW-1:0] lowest_set(input logic [N_AXON-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = N_AXON - 1; i >= 0; i--) if (v[i]) r = AW'(i);
    return r;
  endfunction

  assign pick_axon  = lowest_set(act_q);
  assign any_active = |act_q;

  always_comb begin
    clr_vec = '0;
    set_vec = '0;
    if (take)    clr_vec[pick_axon] = 1'b1;
    if (ev_fire) set_vec[ev_axon]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      act_q  <= (act_q & ~clr_vec) | (tick ? pend_q : '0);
      pend_q <= (tick ? '0 : pend_q) | set_vec;
    end
  end

  AST_DELIVERED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(tick && pend_q[pick_axon]) |=> !act_q[$past(pick_axon)]); // R3
  AST_EVENT_COLLECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> pend_q[$past(ev_axon)]); // R2
  AST_TICK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ev_fire |=> pend_q == '0); // R7
endmodule

// File: rtl/axfo_xbar.sv
module axfo_xbar
  import axfo_pkg::*;
#(
  parameter int N_AXON = 64,
  parameter int N_NEUR = 32,
  localparam int AW = $clog2(N_AXON)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_axon,
  input  logic [N_NEUR-1:0] cfg_row,
  input  syn_type_t         cfg_type,
  input  logic [AW-1:0]     rd_axon,
  output logic [N_NEUR-1:0] rd_row,
  output syn_type_t         rd_type
);
  logic [N_NEUR-1:0] row_q  [N_AXON];
  syn_type_t         type_q [N_AXON];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < N_AXON; a++) begin
        row_q[a]  <= '0;
        type_q[a] <= '0;
      end
    end else if (cfg_we) begin
      row_q[cfg_axon]  <= cfg_row;
      type_q[cfg_axon] <= cfg_type;
    end
  end

  assign rd_row  = row_q[rd_axon];
  assign rd_type = type_q[rd_axon];

  AST_CFG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> row_q[$past(cfg_axon)] == $past(cfg_row)); // R10
endmodule

// File: rtl/axfo_outreg.sv
module axfo_outreg
  import axfo_pkg::*;
#(
  parameter int N_AXON = 64,
  parameter int N_NEUR = 32,
  localparam int AW = $clog2(N_AXON)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_active,
  input  logic [AW-1:0]     rd_axon,
  input  logic [N_NEUR-1:0] rd_row,
  input  syn_type_t         rd_type,
  input  logic              out_ready,
  output logic              take,
  output logic              out_valid,
  output logic [AW-1:0]     out_axon,
  output logic [N_NEUR-1:0] out_row,
  output syn_type_t         out_type
);
  assign take = any_active && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_axon  <= '0;
      out_row   <= '0;
      out_type  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_axon  <= rd_axon;
      out_row   <= rd_row;
      out_type  <= rd_type;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_axon) && $stable(out_row) && $stable(out_type)); // R6
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_axon == $past(rd_axon)); // R4
endmodule

// File: rtl/axon_fanout.sv
module axon_fanout
  import axfo_pkg::*;
#(
  parameter int N_AXON = 64,
  parameter int N_NEUR = 32,
  localparam int AW = $clog2(N_AXON)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [AW-1:0]     ev_axon,
  input  logic              tick,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_axon,
  input  logic [N_NEUR-1:0] cfg_row,
  input  logic [TYPE_W-1:0] cfg_type,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_axon,
  output logic [N_NEUR-1:0] out_row,
  output logic [TYPE_W-1:0] out_type,
  output logic              done
);
  logic              ev_fire, take, any_active;
  logic [AW-1:0]     pick_axon;
  logic [N_NEUR-1:0] rd_row;
  syn_type_t         rd_type;

  assign ev_ready = 1'b1;
  assign ev_fire  = ev_valid && ev_ready;

  axfo_activity #(.N_AXON(N_AXON)) u_act (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_axon(ev_axon), .tick(tick),
    .take(take), .pick_axon(pick_axon), .any_active(any_active));

  axfo_xbar #(.N_AXON(N_AXON), .N_NEUR(N_NEUR)) u_xbar (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_axon(cfg_axon), .cfg_row(cfg_row),
    .cfg_type(cfg_type), .rd_axon(pick_axon), .rd_row(rd_row), .rd_type(rd_type));

  axfo_outreg #(.N_AXON(N_AXON), .N_NEUR(N_NEUR)) u_out (
    .clk(clk), .rst_n(rst_n), .any_active(any_active), .rd_axon(pick_axon), .rd_row(rd_row),
    .rd_type(rd_type), .out_ready(out_ready), .take(take), .out_valid(out_valid),
    .out_axon(out_axon), .out_row(out_row), .out_type(out_type));

  assign done = !any_active && !out_valid;

  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !tick |=> done); // R8
  AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tick && done |=> !out_valid); // R4
endmodule

// File: tb/axon_fanout_bench.sv
module axon_fanout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 64;
  localparam int NN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, tick = 0, cfg_we = 0, out_ready = 0;
  logic [5:0] ev_axon = '0, cfg_axon = '0;
  logic [NN-1:0] cfg_row = '0;
  logic [1:0] cfg_type = '0;
  logic ev_ready, out_valid, done;
  logic [5:0] out_axon;
  logic [NN-1:0] out_row;
  logic [1:0] out_type;

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  bit m_pend[NA], m_act[NA];
  logic [NN-1:0] m_row[NA];
  int m_typ[NA];
  bit m_ov;
  int m_ax, m_otyp;
  logic [NN-1:0] m_orow;
  int deliv[$], deliv_cyc[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  axon_fanout u_axon_fanout (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_axon(ev_axon),
    .tick(tick), .cfg_we(cfg_we), .cfg_axon(cfg_axon), .cfg_row(cfg_row), .cfg_type(cfg_type),
    .out_valid(out_valid), .out_ready(out_ready), .out_axon(out_axon), .out_row(out_row),
    .out_type(out_type), .done(done));

  function automatic logic [NN-1:0] pattern(input int a);
    logic [NN-1:0] v;
    v = NN'(32'h9E3779B9 * (a + 1)) ^ NN'(a << 3);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_done();
    for (int i = 0; i < NA; i++) if (m_act[i]) return 0;
    return !m_ov;
  endfunction

  task automatic compare();
    bit ok;
    ok = (out_valid == m_ov) && (done == model_done()) && ev_ready;
    if (ok && m_ov) ok = (out_axon == 6'(m_ax)) && (out_row == m_orow) && (int'(out_type) == m_otyp);
    check(ok, cur_req, "model compare valid/axon/row", {out_valid, out_axon, out_row},
          {m_ov, 6'(m_ax), m_orow});
  endtask

  task automatic step();
    bit any; int p; bit n_ov; int n_ax, n_typ; logic [NN-1:0] n_row;
    any = 0; p = 0;
    for (int i = NA - 1; i >= 0; i--) if (m_act[i]) begin any = 1; p = i; end
    n_ov = m_ov; n_ax = m_ax; n_row = m_orow; n_typ = m_otyp;
    if (out_valid && out_ready) begin deliv.push_back(int'(out_axon)); deliv_cyc.push_back(cyc); end
    if (any && (!m_ov || out_ready)) begin
      n_ov = 1; n_ax = p; n_row = m_row[p]; n_typ = m_typ[p];
    end else if (out_ready) n_ov = 0;
    @(posedge clk);
    cyc++;
    if (any && (!m_ov || out_ready)) m_act[p] = 0;
    m_ov = n_ov; m_ax = n_ax; m_orow = n_row; m_otyp = n_typ;
    for (int i = 0; i < NA; i++) if (tick && m_pend[i]) m_act[i] = 1;
    if (tick) for (int i = 0; i < NA; i++) m_pend[i] = 0;
    if (ev_valid) m_pend[ev_axon] = 1;
    if (cfg_we) begin m_row[cfg_axon] = cfg_row; m_typ[cfg_axon] = int'(cfg_type); end
    @(negedge clk);
    compare();
  endtask

  task automatic send(input int a);
    ev_valid = 1; ev_axon = 6'(a); step(); ev_valid = 0;
  endtask

  task automatic do_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 300 && !(done && !out_valid); k++) step();
    step();
  endtask

  task automatic check_order(input string req, input int exp[$], input bit back_to_back);
    check(deliv.size() == exp.size(), req, "delivery count", deliv.size(), exp.size());
    for (int i = 0; i < exp.size() && i < deliv.size(); i++)
      check(deliv[i] == exp[i], req, $sformatf("delivery %0d axon", i), deliv[i], exp[i]);
    if (back_to_back)
      for (int i = 1; i < deliv_cyc.size(); i++)
        check(deliv_cyc[i] == deliv_cyc[i-1] + 1, "R4", "beats on consecutive cycles",
              deliv_cyc[i] - deliv_cyc[i-1], 1);
    deliv.delete(); deliv_cyc.delete();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NN-1:0] old20;
    for (int i = 0; i < NA; i++) begin m_pend[i] = 0; m_act[i] = 0; m_row[i] = '0; m_typ[i] = 0; end
    m_ov = 0; m_ax = 0; m_orow = '0; m_otyp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1", "out_valid at reset", out_valid, 0);
    check(done == 1, "R1", "done at reset", done, 1);
    check(ev_ready == 1, "R1", "ev_ready at reset", ev_ready, 1);
    rst_n = 1;
    cur_req = "R5";
    for (int a = 0; a < NA; a++) begin
      cfg_we = 1; cfg_axon = 6'(a); cfg_row = pattern(a); cfg_type = 2'(a % 3); step();
    end
    cfg_we = 0;

    // R2 / R3 / R4: collect without tick, duplicates, ascending order
    cur_req = "R2";
    send(5); send(1); send(40); send(5); send(63); send(0); send(5);
    repeat (6) step();
    check(out_valid == 0, "R2", "no beat before tick", out_valid, 0);
    check(done == 1, "R8", "done while nothing latched", done, 1);
    out_ready = 1; cur_req = "R4";
    do_tick();
    check(out_valid == 0, "R4", "beat not yet valid one edge after tick", out_valid, 0);
    step();
    check(out_valid == 1 && out_axon == 0, "R4", "first beat axon 0", {out_valid, out_axon}, {1'b1, 6'd0});
    check(out_row == pattern(0) && out_type == 2'd0, "R5", "row/type of axon 0", out_row, pattern(0));
    drain();
    check_order("R3", '{0, 1, 5, 40, 63}, 1);

    // R6 backpressure
    cur_req = "R6";
    send(2); send(3); send(10); send(50);
    out_ready = 0; do_tick();
    for (int k = 0; k < 30; k++) begin out_ready = (k % 3 == 2); step(); end
    out_ready = 1; drain();
    check_order("R6", '{2, 3, 10, 50}, 0);

    // R7 events during replay and with the tick
    cur_req = "R7";
    send(12);
    ev_valid = 1; ev_axon = 6'd14; do_tick(); ev_valid = 0;
    send(13);
    drain();
    check_order("R7", '{12}, 1);
    do_tick(); drain();
    check_order("R7", '{13, 14}, 1);

    // R9 tick mid-replay with stalled output
    cur_req = "R9";
    out_ready = 0;
    send(30); send(31); send(32);
    do_tick(); step(); step();
    send(33); send(1);
    do_tick();
    out_ready = 1; drain();
    check_order("R9", '{30, 1, 31, 32, 33}, 0);

    // R10 config write colliding with the row read
    cur_req = "R10";
    out_ready = 0; old20 = pattern(20);
    send(19); send(20);
    do_tick(); step(); step();
    out_ready = 1; cfg_we = 1; cfg_axon = 6'd20; cfg_row = ~old20; cfg_type = 2'd3; step();
    cfg_we = 0;
    check(out_axon == 20 && out_row == old20, "R10", "same-cycle write leaves old row", out_row, old20);
    drain(); deliv.delete(); deliv_cyc.delete();
    send(20); do_tick(); step(); step();
    check(out_row == ~old20 && out_type == 2'd3, "R10", "new row after write", out_row, ~old20);
    drain();
    check(done == 1, "R8", "done after drain", done, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule